// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes configuration words from a single serial line and turns them into parallel settings for the analog receive and transmit paths. The line is sampled on each rising edge of the block clock (the master clock). While idle, the line rests high. A low sample marks the first bit of a 16-bit burst. After that low bit come 12 payload bits and then 3 register-select bits, each field most significant bit first. The bit after the burst is a stop bit. A high stop bit writes the payload into the selected register on that same edge. A low stop bit discards the whole frame.

The stored settings are offered as plain parallel outputs. These are the receive attenuator code, the low-noise amplifier gain code, the transmit pre-driver gain code and the timing-recovery DAC code. Two further slots are test registers: an override word and a raw test-control word. They are written like any other slot. They take effect only while the test strap input is high; otherwise the normal settings drive the outputs. The block has no data stream with flow control. The serial line cannot be stalled, so there is no back-pressure, and every output is a plain level.

Top module: `serial_cfg_rx`

## Requirements
- R1: While `rst_n` is low, and after it returns high, the outputs show their defaults until a frame commits. The defaults are: attenuator 2'b00, LNA gain 0, TX gain 0, timing DAC 8'h80, test control 0. A reset in the middle of a frame discards that frame.
- R2: `cfg_sd` is sampled only on rising clock edges. While idle, high samples do nothing. The first low sample starts a frame.
- R3: After the start bit, the next 12 samples form the payload and the next 3 form the select field, each received most significant bit first.
- R4: When the sample after the select field is high, the payload is written on that edge. The new output value is visible after that edge. Outputs never change on any other edge, except through `test_en` or reset.
- R5: When the sample after the select field is low, no register changes. The receiver then hunts for a new start bit from the next sample on.
- R6: Select 0 stores the attenuator code from payload[1:0]. Code 2'b11 means 0 dB and 2'b00 means -15 dB, in 5 dB steps.
- R7: Select 1 stores the LNA gain code from payload[4:0], in 1 dB steps. Code 0 means 0 dB and code 31 means +31 dB.
- R8: Select 2 stores the TX pre-driver gain code from payload[3:0], where code 0 means -9 dB and each step adds 1 dB. Select 3 stores the timing DAC code from payload[7:0].
- R9: Select 6 (the override word) and select 7 (test control) are always stored, whatever the level of `test_en`. In the override word, [1:0] is the attenuator, [6:2] is the LNA gain and [10:7] is the TX gain.
- R10: While `test_en` is low, the attenuator, LNA and TX gain outputs follow the normal slots and `test_ctrl_o` reads 0. While `test_en` is high, those three outputs come from the override word and `test_ctrl_o` shows the select-7 word.
- R11: A frame that commits to select 4 or 5 changes no output.
- R12: A start bit sampled on the edge right after a stop bit begins a new frame; no idle gap is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the serial line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sd | input | 1 | Serial configuration line, idle high |
| test_en | input | 1 | Test strap; high lets the test registers take effect |
| atten_o | output | 2 | Receive attenuator code |
| lna_gain_o | output | 5 | LNA gain code |
| tx_gain_o | output | 4 | TX pre-driver gain code |
| timing_dac_o | output | 8 | Timing-recovery DAC code |
| test_ctrl_o | output | 12 | Test control word, zero unless test_en is high |

## Verification
Two events can fall on the same edge. One is a frame committing to the override slot; the other is `test_en` changing level. The bench provokes this by toggling the strap on the very clock in which the stop bit of an override frame is sampled. It then judges the outputs on every following cycle against a behavioural model that applies the write first and the strap selection second. A second coincidence is tested too: a stop bit directly followed by the start bit of the next frame. Both frames must land, and the second must not lose its leading bit.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BODY = 2'd1,
    RX_STOP = 2'd2
  } rx_state_t;

  // Slot numbers: decoded by the register bank and the output selector
  localparam int unsigned SLOT_ATT  = 0;
  localparam int unsigned SLOT_LNA  = 1;
  localparam int unsigned SLOT_TXG  = 2;
  localparam int unsigned SLOT_DAC  = 3;
  localparam int unsigned SLOT_TOVR = 6;
  localparam int unsigned SLOT_TCTL = 7;

endpackage

// File: rtl/cfgrx_deser.sv
module cfgrx_deser
  import cfgrx_pkg::*;
#(
  parameter int PAY_W = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_i,
  output logic             commit_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [PAY_W-1:0] data_o,
  output rx_state_t        state_o
);

  localparam int BODY_W = PAY_W + SEL_W;
  localparam int CNT_W  = $clog2(BODY_W);

  rx_state_t         st_q;
  logic [BODY_W-1:0] body_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      body_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!sd_i) st_q <= RX_BODY;
        end
        RX_BODY: begin
          body_q <= {body_q[BODY_W-2:0], sd_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BODY_W - 1)) st_q <= RX_STOP;
        end
        RX_STOP: st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  // Stop bit is judged on the same edge that writes the register
  assign commit_o = (st_q == RX_STOP) && sd_i;
  assign sel_o    = body_q[SEL_W-1:0];
  assign data_o   = body_q[BODY_W-1:SEL_W];
  assign state_o  = st_q;

endmodule

// File: rtl/cfgrx_regbank.sv
module cfgrx_regbank #(
  parameter int                    PAY_W     = 12,
  parameter int                    SEL_W     = 3,
  parameter int                    NREG      = 1 << SEL_W,
  parameter logic [NREG-1:0]       IMPL_MASK = '1,
  parameter logic [NREG*PAY_W-1:0] RST_VALS  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [PAY_W-1:0]      wr_data,
  output logic [NREG*PAY_W-1:0] regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (IMPL_MASK[g]) begin : g_live
      logic [PAY_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    slot_q <= RST_VALS[g*PAY_W +: PAY_W];
        else if (wr_en && (wr_sel == SEL_W'(g)))       slot_q <= wr_data;
      end
      assign regs_o[g*PAY_W +: PAY_W] = slot_q;
    end else begin : g_hole
      assign regs_o[g*PAY_W +: PAY_W] = RST_VALS[g*PAY_W +: PAY_W];
    end
  end

endmodule

// File: rtl/cfgrx_outsel.sv
module cfgrx_outsel
  import cfgrx_pkg::*;
#(
  parameter int PAY_W = 12,
  parameter int NREG  = 8,
  parameter int ATT_W = 2,
  parameter int LNA_W = 5,
  parameter int TXG_W = 4,
  parameter int DAC_W = 8
) (
  input  logic [NREG*PAY_W-1:0] regs_i,
  input  logic                  test_en,
  output logic [ATT_W-1:0]      atten_o,
  output logic [LNA_W-1:0]      lna_o,
  output logic [TXG_W-1:0]      txg_o,
  output logic [DAC_W-1:0]      dac_o,
  output logic [PAY_W-1:0]      tctl_o
);

  localparam int OV_ATT = 0;
  localparam int OV_LNA = OV_ATT + ATT_W;
  localparam int OV_TXG = OV_LNA + LNA_W;
  localparam int OV_END = OV_TXG + TXG_W;

  logic [PAY_W-1:0] att_w, lna_w, txg_w, dac_w, ovr_w, tctl_w;

  assign att_w  = regs_i[SLOT_ATT*PAY_W  +: PAY_W];
  assign lna_w  = regs_i[SLOT_LNA*PAY_W  +: PAY_W];
  assign txg_w  = regs_i[SLOT_TXG*PAY_W  +: PAY_W];
  assign dac_w  = regs_i[SLOT_DAC*PAY_W  +: PAY_W];
  assign ovr_w  = regs_i[SLOT_TOVR*PAY_W +: PAY_W];
  assign tctl_w = regs_i[SLOT_TCTL*PAY_W +: PAY_W];

  always_comb begin
    if (test_en) begin
      atten_o = ovr_w[OV_ATT +: ATT_W];
      lna_o   = ovr_w[OV_LNA +: LNA_W];
      txg_o   = ovr_w[OV_TXG +: TXG_W];
      tctl_o  = tctl_w;
    end else begin
      atten_o = att_w[ATT_W-1:0];
      lna_o   = lna_w[LNA_W-1:0];
      txg_o   = txg_w[TXG_W-1:0];
      tctl_o  = '0;
    end
  end

  assign dac_o = dac_w[DAC_W-1:0];

  logic unused_slot_bits;
  assign unused_slot_bits = ^{regs_i, ovr_w[PAY_W-1:OV_END]};

endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
  import cfgrx_pkg::*;
#(
  parameter int PAY_W   = 12,
  parameter int SEL_W   = 3,
  parameter int ATT_W   = 2,
  parameter int LNA_W   = 5,
  parameter int TXG_W   = 4,
  parameter int DAC_W   = 8,
  parameter int ATT_RST = 0,
  parameter int DAC_RST = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sd,
  input  logic             test_en,
  output logic [ATT_W-1:0] atten_o,
  output logic [LNA_W-1:0] lna_gain_o,
  output logic [TXG_W-1:0] tx_gain_o,
  output logic [DAC_W-1:0] timing_dac_o,
  output logic [PAY_W-1:0] test_ctrl_o
);

  localparam int              NREG      = 1 << SEL_W;
  localparam logic [NREG-1:0] IMPL_MASK = NREG'((1 << SLOT_ATT) | (1 << SLOT_LNA) |
                                                (1 << SLOT_TXG) | (1 << SLOT_DAC) |
                                                (1 << SLOT_TOVR) | (1 << SLOT_TCTL));
  localparam logic [NREG*PAY_W-1:0] RST_VALS =
      ((NREG*PAY_W)'(ATT_RST) << (SLOT_ATT*PAY_W)) |
      ((NREG*PAY_W)'(DAC_RST) << (SLOT_DAC*PAY_W));

  logic                  wr_en;
  logic [SEL_W-1:0]      wr_sel;
  logic [PAY_W-1:0]      wr_data;
  rx_state_t             rx_state;
  logic [NREG*PAY_W-1:0] regs;

  cfgrx_deser #(.PAY_W(PAY_W), .SEL_W(SEL_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_i     (cfg_sd),
    .commit_o (wr_en),
    .sel_o    (wr_sel),
    .data_o   (wr_data),
    .state_o  (rx_state)
  );

  cfgrx_regbank #(
    .PAY_W(PAY_W), .SEL_W(SEL_W), .NREG(NREG),
    .IMPL_MASK(IMPL_MASK), .RST_VALS(RST_VALS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  cfgrx_outsel #(
    .PAY_W(PAY_W), .NREG(NREG), .ATT_W(ATT_W),
    .LNA_W(LNA_W), .TXG_W(TXG_W), .DAC_W(DAC_W)
  ) u_sel (
    .regs_i  (regs),
    .test_en (test_en),
    .atten_o (atten_o),
    .lna_o   (lna_gain_o),
    .txg_o   (tx_gain_o),
    .dac_o   (timing_dac_o),
    .tctl_o  (test_ctrl_o)
  );

endmodule

// File: rtl/serial_cfg_rx_chk.sv
module serial_cfg_rx_chk
  import cfgrx_pkg::*;
#(
  parameter int PAY_W = 12,
  parameter int SEL_W = 3,
  parameter int ATT_W = 2,
  parameter int LNA_W = 5,
  parameter int TXG_W = 4,
  parameter int DAC_W = 8,
  parameter int NREG  = 8,
  parameter logic [NREG-1:0] IMPL_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_sd,
  input logic             test_en,
  input logic [ATT_W-1:0] atten_o,
  input logic [LNA_W-1:0] lna_gain_o,
  input logic [TXG_W-1:0] tx_gain_o,
  input logic [DAC_W-1:0] timing_dac_o,
  input logic [PAY_W-1:0] test_ctrl_o,
  input rx_state_t        rx_state,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel
);

  localparam int BODY_W = PAY_W + SEL_W;
  localparam int AGE_W  = $clog2(BODY_W + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // Edges since the start bit was sampled
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            age_q <= AGE_MAX;
    else if (rx_state == RX_IDLE && !cfg_sd) age_q <= AGE_W'(1);
    else if (age_q != AGE_MAX)             age_q <= age_q + 1'b1;
  end

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> age_q == AGE_W'(BODY_W + 1)); // R3

  AST_DAC_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timing_dac_o) |-> $past(wr_en)); // R4

  AST_LNA_NEEDS_HIGH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(test_en) && !$stable(lna_gain_o)) |-> $past(cfg_sd)); // R5

  AST_TEST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> test_ctrl_o == '0); // R10

  AST_HOLE_SLOT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !IMPL_MASK[wr_sel]) |=>
      (!$stable(test_en) || ($stable(atten_o) && $stable(lna_gain_o) &&
       $stable(tx_gain_o) && $stable(timing_dac_o) && $stable(test_ctrl_o)))); // R11

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state == RX_STOP |=> rx_state != RX_STOP); // R12

endmodule

bind serial_cfg_rx serial_cfg_rx_chk #(
  .PAY_W(PAY_W), .SEL_W(SEL_W), .ATT_W(ATT_W), .LNA_W(LNA_W),
  .TXG_W(TXG_W), .DAC_W(DAC_W), .NREG(NREG), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_sd       (cfg_sd),
  .test_en      (test_en),
  .atten_o      (atten_o),
  .lna_gain_o   (lna_gain_o),
  .tx_gain_o    (tx_gain_o),
  .timing_dac_o (timing_dac_o),
  .test_ctrl_o  (test_ctrl_o),
  .rx_state     (rx_state),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel)
);

// File: tb/serial_cfg_rx_test.sv
module serial_cfg_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sd = 1'b1;
  logic        test_en = 1'b0;
  logic [1:0]  atten_o;
  logic [4:0]  lna_gain_o;
  logic [3:0]  tx_gain_o;
  logic [7:0]  timing_dac_o;
  logic [11:0] test_ctrl_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_cfg_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_sd(cfg_sd), .test_en(test_en),
    .atten_o(atten_o), .lna_gain_o(lna_gain_o), .tx_gain_o(tx_gain_o),
    .timing_dac_o(timing_dac_o), .test_ctrl_o(test_ctrl_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_slot [8];
  int m_mode;       // 0 hunting, 1 collecting, 2 awaiting stop
  bit m_bits [$];

  task automatic model_reset();
    foreach (m_slot[i]) m_slot[i] = 0;
    m_slot[3] = 128;
    m_mode = 0;
    m_bits.delete();
  endtask

  task automatic model_commit();
    int pay = 0;
    int sel = 0;
    for (int i = 0; i < 12; i++) pay = pay * 2 + int'(m_bits[i]);
    for (int i = 12; i < 15; i++) sel = sel * 2 + int'(m_bits[i]);
    m_slot[sel] = pay;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      case (m_mode)
        0: if (cfg_sd == 1'b0) begin m_mode = 1; m_bits.delete(); end
        1: begin
          m_bits.push_back(cfg_sd);
          if (m_bits.size() == 15) m_mode = 2;
        end
        default: begin
          if (cfg_sd == 1'b1) model_commit();
          m_mode = 0;
        end
      endcase
    end
  end

  function automatic int exp_att();  return test_en ? (m_slot[6] & 3)        : (m_slot[0] & 3);  endfunction
  function automatic int exp_lna();  return test_en ? ((m_slot[6] >> 2) & 31) : (m_slot[1] & 31); endfunction
  function automatic int exp_txg();  return test_en ? ((m_slot[6] >> 7) & 15) : (m_slot[2] & 15); endfunction
  function automatic int exp_tctl(); return test_en ? m_slot[7] : 0; endfunction

  task automatic chk(input int act, input int exp, input string req);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(atten_o),      exp_att(),     "R6 per-cycle atten");
      chk(int'(lna_gain_o),   exp_lna(),     "R7 per-cycle lna");
      chk(int'(tx_gain_o),    exp_txg(),     "R8 per-cycle txgain");
      chk(int'(timing_dac_o), m_slot[3] & 255, "R8 per-cycle dac");
      chk(int'(test_ctrl_o),  exp_tctl(),    "R10 per-cycle testctrl");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_frame(input int sel, input int pay, input bit stopv,
                            input bit tail, input bit flip_at_stop = 0);
    @(negedge clk); cfg_sd = 1'b0;
    for (int i = 11; i >= 0; i--) begin @(negedge clk); cfg_sd = pay[i]; end
    for (int i = 2; i >= 0; i--)  begin @(negedge clk); cfg_sd = sel[i]; end
    @(negedge clk); cfg_sd = stopv;
    if (flip_at_stop) test_en = ~test_en;
    if (tail) begin @(negedge clk); cfg_sd = 1'b1; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); cfg_sd = 1'b1; end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: defaults while in reset
    chk(int'(atten_o), 0, "R1 reset atten");
    chk(int'(timing_dac_o), 128, "R1 reset dac");
    rst_n = 1'b1;
    idle(6);
    chk(int'(lna_gain_o), 0, "R1 lna after reset");
    chk(int'(test_ctrl_o), 0, "R1 testctrl after reset");
    chk(int'(atten_o), 0, "R2 idle highs leave atten");

    send_frame(0, 12'h003, 1, 1);
    chk(int'(atten_o), 3, "R6 atten 0dB code");
    send_frame(1, 12'hABD, 1, 1);
    chk(int'(lna_gain_o), 29, "R7 lna from low payload bits");
    send_frame(2, 12'h00A, 1, 1);
    chk(int'(tx_gain_o), 10, "R8 tx gain");
    send_frame(3, 12'h3C5, 1, 1);
    chk(int'(timing_dac_o), 8'hC5, "R3 msb-first dac");

    send_frame(3, 12'h011, 0, 1);
    chk(int'(timing_dac_o), 8'hC5, "R5 low stop drops frame");
    send_frame(3, 12'h001, 1, 1);
    chk(int'(timing_dac_o), 1, "R5 receiver recovers");

    send_frame(4, 12'hFFF, 1, 1);
    send_frame(5, 12'hFFF, 1, 1);
    chk(int'(atten_o), 3, "R11 hole slot atten");
    chk(int'(lna_gain_o), 29, "R11 hole slot lna");
    chk(int'(timing_dac_o), 1, "R11 hole slot dac");

    send_frame(6, 12'h61E, 1, 1);
    send_frame(7, 12'h5A5, 1, 1);
    chk(int'(atten_o), 3, "R10 strap low keeps normal atten");
    chk(int'(test_ctrl_o), 0, "R10 strap low masks testctrl");
    @(negedge clk); test_en = 1'b1;
    @(negedge clk);
    chk(int'(atten_o), 2, "R9 override atten");
    chk(int'(lna_gain_o), 7, "R9 override lna");
    chk(int'(tx_gain_o), 12, "R9 override txgain");
    chk(int'(test_ctrl_o), 12'h5A5, "R10 strap high shows testctrl");

    // Override commit on the same edge the strap falls
    send_frame(6, 12'h003, 1, 1, 1);
    chk(int'(atten_o), 3, "R10 strap fell: normal atten");
    @(negedge clk); test_en = 1'b1;
    @(negedge clk);
    chk(int'(atten_o), 3, "R9 override written during strap change");
    chk(int'(lna_gain_o), 0, "R9 override lna field");
    @(negedge clk); test_en = 1'b0;

    // Back-to-back frames
    send_frame(1, 12'h004, 1, 0);
    send_frame(2, 12'h003, 1, 1);
    chk(int'(lna_gain_o), 4, "R12 first of pair");
    chk(int'(tx_gain_o), 3, "R12 second of pair");

    // Reset in the middle of a frame
    @(negedge clk); cfg_sd = 1'b0;
    repeat (5) begin @(negedge clk); cfg_sd = 1'b1; end
    rst_n = 1'b0;
    @(negedge clk); cfg_sd = 1'b1;
    chk(int'(lna_gain_o), 0, "R1 mid-frame reset lna");
    chk(int'(timing_dac_o), 128, "R1 mid-frame reset dac");
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    send_frame(1, 12'h01F, 1, 1);
    chk(int'(lna_gain_o), 31, "R4 frame after reset lands");
    idle(4);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule